// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions a small set of external interrupt request pins before they reach an interrupt encoder. Every pin is first brought into the clock domain through a synchroniser. It is then judged against its own two-bit sense code: active-high level, rising edge, falling edge or active-low level. A per-line enable gates the result into one qualified request per line.

Edge events are held in a per-line latch until software clears them through a write-one-to-clear acknowledge bit. Level-sensed lines simply follow the synchronised pin. All sense codes, enables and acknowledge strobes share one 32-bit control word, written and read through a plain register port. Line 0 leaves the block on the critical-class request output and the remaining lines on the main-class outputs. Prioritisation between classes belongs to the encoder downstream.

Top module: `ext_irq_sense`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the control word reads 0, every sense code is 0 (active-high level), every line is disabled and no request output is high.
- R2: The control word holds the sense code of line n in bits [23-2n:22-2n] and the enable of line n in bit 11-n. All other bits read back as 0, including the acknowledge bits 27-n.
- R3: With sense code 0 (active-high level) and the line enabled, the request follows the pin. It goes high two clock edges after the pin goes high and low two edges after it falls.
- R4: With sense code 3 (active-low level) and the line enabled, the request is high while the synchronised pin is low.
- R5: With sense code 1 (rising edge), a low-to-high pin transition latches an event. The request rises three clock edges after the pin change and stays high after the pin returns low.
- R6: With sense code 2 (falling edge), a high-to-low transition latches an event in the same way. A rising transition does not.
- R7: Writing 1 to control bit 27-n clears the latched event of line n on that write. Latched events on other lines are untouched.
- R8: When an edge is detected at the same clock edge as the acknowledge write for that line, the event stays latched.
- R9: With the enable bit at 0 the request is low. An edge arriving while the line is masked is still latched and appears as soon as the line is enabled.
- R10: A write that changes a line's sense code clears that line's latched event.
- R11: crit_req_o carries the request of line 0, and main_req_o[k] carries the request of line k+1.
- R12: In the level modes (codes 0 and 3) an acknowledge write has no effect on the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | 4 | Asynchronous external interrupt pins, bit n is line n |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data, including acknowledge bits |
| rd_data_o | output | 32 | Control word read-back |
| line_req_o | output | 4 | Qualified request per line |
| crit_req_o | output | 1 | Critical-class request (line 0) |
| main_req_o | output | 3 | Main-class requests (lines 1 to 3) |

## Verification
The bench builds the block with its default parameters: four lines, a two-stage synchroniser and the descending field layout from bit 23, bit 11 and bit 27. Four lines are enough to check the descending bit order across the whole word. They also allow one line's acknowledge to be made while a neighbour holds a latched event, and the split between the critical and main outputs to be observed. The two-stage depth fixes the exact edge counts that the bench samples on, so it also exercises the collision between an acknowledge and a newly detected edge.

// File: rtl/eis_pkg.sv
// Package: shared types for the external interrupt sense controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package eis_pkg;

    // Per-line sense code as stored in the control word.
    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'd0,
        SENSE_RISE   = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_LVL_LO = 2'd3
    } sense_e;

    // True when the code selects an edge-latched mode.
    function automatic logic is_edge_mode(input sense_e s);
        return (s == SENSE_RISE) || (s == SENSE_FALL);
    endfunction

endpackage

// File: rtl/eis_sync.sv
// Module: eis_sync
// Multi-stage flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency required) and
// STAGES >= 2. Synchronous active-low reset clears every stage.
module eis_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    // Remaining stages shift the sample along the chain.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/eis_ctrl_reg.sv
// Module: eis_ctrl_reg
// Holds the shared control word: per-line sense codes and enables.
// Acknowledge bits are not stored; a write with such a bit set raises a
// one-cycle strobe for that line. A write that changes a line's sense code
// raises that line's change strobe. Assumes the three field groups do not
// overlap for the chosen parameters; bits outside them read as 0.
module eis_ctrl_reg #(
    parameter int NUM_LINES = 4,
    parameter int DATA_W    = 32,
    parameter int SENSE_MSB = 23,
    parameter int EN_MSB    = 11,
    parameter int ACK_MSB   = 27
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    output logic [DATA_W-1:0]                 rd_data_o,
    output eis_pkg::sense_e [NUM_LINES-1:0]   sense_o,
    output logic [NUM_LINES-1:0]              en_o,
    output logic [NUM_LINES-1:0]              ack_o,
    output logic [NUM_LINES-1:0]              chg_o
);

    localparam int SENSE_LSB = SENSE_MSB - 2*NUM_LINES + 1;
    localparam int EN_LSB    = EN_MSB - NUM_LINES + 1;

    eis_pkg::sense_e [NUM_LINES-1:0] sense_q;
    logic [NUM_LINES-1:0]            en_q;
    logic [DATA_W-1:0]               used_mask;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        localparam int SB = SENSE_MSB - 2*n;
        localparam int EB = EN_MSB - n;
        localparam int AB = ACK_MSB - n;

        eis_pkg::sense_e wr_sense;
        assign wr_sense = eis_pkg::sense_e'(wr_data_i[SB -: 2]);

        // Update this line's sense code and enable on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sense_q[n] <= eis_pkg::SENSE_LVL_HI;
                en_q[n]    <= 1'b0;
            end else if (wr_en_i) begin
                sense_q[n] <= wr_sense;
                en_q[n]    <= wr_data_i[EB];
            end
        end

        // Strobes: acknowledge and sense-code change for this line.
        assign ack_o[n] = wr_en_i & wr_data_i[AB];
        assign chg_o[n] = wr_en_i & (wr_sense != sense_q[n]);
    end

    // Place stored fields into the read-back word; all else reads zero.
    always_comb begin
        rd_data_o = '0;
        used_mask = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            rd_data_o[SENSE_MSB - 2*n -: 2] = sense_q[n];
            rd_data_o[EN_MSB - n]           = en_q[n];
            used_mask[SENSE_MSB - 2*n -: 2] = 2'b11;
            used_mask[EN_MSB - n]           = 1'b1;
            used_mask[ACK_MSB - n]          = 1'b1;
        end
    end

    // Bits of the write word that carry no field are deliberately dropped.
    logic unused_wr_bits;
    assign unused_wr_bits = ^(wr_data_i & ~used_mask);

    assign sense_o = sense_q;
    assign en_o    = en_q;

    // Layout sanity on the parameters.
    initial begin
        if (SENSE_LSB < 0 || EN_LSB < 0 || ACK_MSB >= DATA_W ||
            SENSE_MSB >= DATA_W || ACK_MSB - NUM_LINES + 1 < 0)
            $display("eis_ctrl_reg: field layout does not fit the word");
    end

endmodule

// File: rtl/eis_line.sv
// Module: eis_line
// One line's sense logic: edge detection against the previous synchronised
// sample, the edge latch with acknowledge, and enable gating.
// Assumes pin_sync_i is already synchronous to clk. A newly detected edge
// wins over a same-cycle acknowledge; a sense-code change clears the latch.
module eis_line (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_sync_i,
    input  eis_pkg::sense_e sense_i,
    input  logic            en_i,
    input  logic            ack_i,
    input  logic            chg_i,
    output logic            latched_o,
    output logic            req_o
);

    logic prev_q;
    logic latch_q;
    logic rise, fall, hit, edge_mode, level_cond;

    // Remember the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_sync_i;
    end

    // Decode the active condition for the selected sense code.
    always_comb begin
        rise       = pin_sync_i & ~prev_q;
        fall       = ~pin_sync_i & prev_q;
        edge_mode  = eis_pkg::is_edge_mode(sense_i);
        hit        = (sense_i == eis_pkg::SENSE_RISE) ? rise : fall;
        level_cond = (sense_i == eis_pkg::SENSE_LVL_LO) ? ~pin_sync_i : pin_sync_i;
    end

    // Edge latch: cleared by code change or level mode, set by edge, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n)                  latch_q <= 1'b0;
        else if (chg_i || !edge_mode) latch_q <= 1'b0;
        else if (hit)                latch_q <= 1'b1;
        else if (ack_i)              latch_q <= 1'b0;
    end

    assign latched_o = latch_q;
    assign req_o     = en_i & (edge_mode ? latch_q : level_cond);

endmodule

// File: rtl/ext_irq_sense.sv
// Module: ext_irq_sense (top)
// External interrupt sense controller: synchronises the pins, applies each
// line's sense code and enable from the shared control word, and splits the
// qualified requests into critical-class and main-class outputs.
// Assumes 1 <= NUM_CRIT < NUM_LINES and a field layout that fits DATA_W.
module ext_irq_sense #(
    parameter int NUM_LINES   = 4,
    parameter int NUM_CRIT    = 1,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32,
    parameter int SENSE_MSB   = 23,
    parameter int EN_MSB      = 11,
    parameter int ACK_MSB     = 27
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINES-1:0]          irq_pin_i,
    input  logic                          wr_en_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    output logic [DATA_W-1:0]             rd_data_o,
    output logic [NUM_LINES-1:0]          line_req_o,
    output logic [NUM_CRIT-1:0]           crit_req_o,
    output logic [NUM_LINES-NUM_CRIT-1:0] main_req_o
);

    localparam int NUM_MAIN = NUM_LINES - NUM_CRIT;

    logic [NUM_LINES-1:0]            pin_sync;
    eis_pkg::sense_e [NUM_LINES-1:0] line_sense;
    logic [NUM_LINES-1:0]            line_en;
    logic [NUM_LINES-1:0]            line_ack;
    logic [NUM_LINES-1:0]            line_chg;
    logic [NUM_LINES-1:0]            line_latched;
    logic [NUM_LINES-1:0]            line_req;

    eis_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_pin_i),
        .sync_o  (pin_sync)
    );

    eis_ctrl_reg #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .SENSE_MSB (SENSE_MSB),
        .EN_MSB    (EN_MSB),
        .ACK_MSB   (ACK_MSB)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .sense_o   (line_sense),
        .en_o      (line_en),
        .ack_o     (line_ack),
        .chg_o     (line_chg)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        eis_line u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_sync_i (pin_sync[n]),
            .sense_i    (line_sense[n]),
            .en_i       (line_en[n]),
            .ack_i      (line_ack[n]),
            .chg_i      (line_chg[n]),
            .latched_o  (line_latched[n]),
            .req_o      (line_req[n])
        );
    end

    // Route the lowest lines to the critical class, the rest to main.
    assign line_req_o = line_req;
    assign crit_req_o = line_req[NUM_CRIT-1:0];
    assign main_req_o = line_req[NUM_LINES-1 -: NUM_MAIN];

endmodule

// File: rtl/ext_irq_sense_chk.sv
// Module: ext_irq_sense_chk
// Property checker bound into ext_irq_sense. Relates the control state,
// the synchronised pins, the edge latches and the requests over time.
module ext_irq_sense_chk #(
    parameter int NUM_LINES = 4,
    parameter int DATA_W    = 32,
    parameter int ACK_MSB   = 27
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_LINES-1:0]            pin_sync,
    input eis_pkg::sense_e [NUM_LINES-1:0] sense,
    input logic [NUM_LINES-1:0]            en,
    input logic [NUM_LINES-1:0]            ack,
    input logic [NUM_LINES-1:0]            chg,
    input logic [NUM_LINES-1:0]            latched,
    input logic [NUM_LINES-1:0]            req,
    input logic [DATA_W-1:0]               rd_data
);

    // R2: acknowledge bits never read back as 1.
    a_r2_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[ACK_MSB -: NUM_LINES] == '0);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        // R9: a masked line never requests.
        a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !en[n] |-> !req[n]);

        // R3: enabled active-high level line mirrors the synchronised pin.
        a_r3_level_high: assert property (@(posedge clk) disable iff (!rst_n)
            (en[n] && sense[n] == eis_pkg::SENSE_LVL_HI) |-> (req[n] == pin_sync[n]));

        // R4: enabled active-low level line mirrors the inverted pin.
        a_r4_level_low: assert property (@(posedge clk) disable iff (!rst_n)
            (en[n] && sense[n] == eis_pkg::SENSE_LVL_LO) |-> (req[n] == !pin_sync[n]));

        // R10: a sense-code change leaves the latch clear.
        a_r10_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
            chg[n] |=> !latched[n]);

        // R5: a latched event holds until an acknowledge or a code change.
        a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (latched[n] && !ack[n] && !chg[n]) |=> latched[n]);

        // R12: level modes never hold a latched event.
        a_r12_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
            (sense[n] == eis_pkg::SENSE_LVL_HI || sense[n] == eis_pkg::SENSE_LVL_LO)
            |=> ($past(chg[n]) || !latched[n] || eis_pkg::is_edge_mode(sense[n])));
    end

endmodule

bind ext_irq_sense ext_irq_sense_chk #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ACK_MSB   (ACK_MSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_sync),
    .sense    (line_sense),
    .en       (line_en),
    .ack      (line_ack),
    .chg      (line_chg),
    .latched  (line_latched),
    .req      (line_req),
    .rd_data  (rd_data_o)
);

// File: tb/ext_irq_sense_test.sv
// Directed bench for ext_irq_sense: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are sampled
// on the falling edge before the next change.
module ext_irq_sense_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_pin = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  line_req;
    logic [0:0]  crit_req;
    logic [2:0]  main_req;

    int total = 0;
    int bad   = 0;

    logic [1:0] sh_sense [4];
    logic       sh_en    [4];

    always #4 clk = ~clk;

    ext_irq_sense uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pin_i  (irq_pin),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .line_req_o (line_req),
        .crit_req_o (crit_req),
        .main_req_o (main_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] shadow_word();
        logic [31:0] w = '0;
        for (int n = 0; n < 4; n++) begin
            w[23 - 2*n -: 2] = sh_sense[n];
            w[11 - n]        = sh_en[n];
        end
        return w;
    endfunction

    task automatic wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        tick(1);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic set_line(input int n, input logic [1:0] code, input logic e);
        sh_sense[n] = code;
        sh_en[n]    = e;
        wr(shadow_word());
    endtask

    task automatic ack_line(input int n);
        wr(shadow_word() | (32'h1 << (27 - n)));
    endtask

    task automatic t_reset;
        chk("R1 read-back", rd_data, 32'h0);
        chk("R1 requests", {28'h0, line_req}, 32'h0);
    endtask

    task automatic t_readback;
        wr(32'hFFFF_FFFF);
        chk("R2 all ones", rd_data, 32'h00FF_0F00);
        chk("R4 all low-level, pins low", {28'h0, line_req}, 32'hF);
        sh_sense[0] = 2'd1; sh_sense[1] = 2'd2; sh_sense[2] = 2'd3; sh_sense[3] = 2'd0;
        sh_en[0] = 1'b1; sh_en[1] = 1'b0; sh_en[2] = 1'b1; sh_en[3] = 1'b0;
        wr(shadow_word());
        chk("R2 mixed layout", rd_data, 32'h006C_0A00);
        set_line(0, 2'd0, 1'b0); set_line(1, 2'd0, 1'b0);
        set_line(2, 2'd0, 1'b0); set_line(3, 2'd0, 1'b0);
        chk("R2 cleared", rd_data, 32'h0);
    endtask

    task automatic t_level_high;
        set_line(3, 2'd0, 1'b1);
        irq_pin[3] = 1'b1;
        tick(1);
        chk("R3 one edge latency", {31'h0, line_req[3]}, 32'h0);
        tick(1);
        chk("R3 high after two edges", {31'h0, line_req[3]}, 32'h1);
        ack_line(3);
        chk("R12 ack ignored in level mode", {31'h0, line_req[3]}, 32'h1);
        irq_pin[3] = 1'b0;
        tick(2);
        chk("R3 follows pin low", {31'h0, line_req[3]}, 32'h0);
        set_line(3, 2'd0, 1'b0);
    endtask

    task automatic t_level_low;
        set_line(2, 2'd3, 1'b1);
        chk("R4 pin low requests", {31'h0, line_req[2]}, 32'h1);
        irq_pin[2] = 1'b1;
        tick(2);
        chk("R4 pin high quiet", {31'h0, line_req[2]}, 32'h0);
        irq_pin[2] = 1'b0;
        tick(2);
        set_line(2, 2'd0, 1'b0);
    endtask

    task automatic t_edges;
        set_line(0, 2'd1, 1'b1);
        set_line(1, 2'd2, 1'b1);
        irq_pin[0] = 1'b1;
        irq_pin[1] = 1'b1;
        tick(2);
        chk("R5 not yet latched", {31'h0, line_req[0]}, 32'h0);
        tick(1);
        chk("R5 rising latched", {31'h0, line_req[0]}, 32'h1);
        chk("R6 rising ignored on falling line", {31'h0, line_req[1]}, 32'h0);
        chk("R11 critical output", {31'h0, crit_req}, 32'h1);
        irq_pin[0] = 1'b0;
        irq_pin[1] = 1'b0;
        tick(3);
        chk("R5 holds after pin low", {31'h0, line_req[0]}, 32'h1);
        chk("R6 falling latched", {31'h0, line_req[1]}, 32'h1);
        chk("R11 main output", {29'h0, main_req}, 32'h1);
        ack_line(0);
        chk("R7 ack clears line 0", {31'h0, line_req[0]}, 32'h0);
        chk("R7 line 1 untouched", {31'h0, line_req[1]}, 32'h1);
        ack_line(1);
        chk("R7 ack clears line 1", {31'h0, line_req[1]}, 32'h0);
    endtask

    task automatic t_same_cycle;
        set_line(3, 2'd1, 1'b1);
        irq_pin[3] = 1'b1;
        tick(2);
        ack_line(3);
        chk("R8 edge beats same-cycle ack", {31'h0, line_req[3]}, 32'h1);
        chk("R11 main line 3", {29'h0, main_req}, 32'h4);
        ack_line(3);
        chk("R8 later ack clears", {31'h0, line_req[3]}, 32'h0);
        irq_pin[3] = 1'b0;
        tick(3);
        set_line(3, 2'd0, 1'b0);
    endtask

    task automatic t_masked;
        set_line(0, 2'd1, 1'b0);
        irq_pin[0] = 1'b1;
        tick(3);
        irq_pin[0] = 1'b0;
        tick(3);
        chk("R9 masked quiet", {31'h0, line_req[0]}, 32'h0);
        set_line(0, 2'd1, 1'b1);
        chk("R9 latched while masked", {31'h0, line_req[0]}, 32'h1);
        ack_line(0);
        chk("R9 cleanup", {31'h0, line_req[0]}, 32'h0);
    endtask

    task automatic t_sense_change;
        set_line(2, 2'd1, 1'b1);
        irq_pin[2] = 1'b1;
        tick(3);
        chk("R10 rising latched first", {31'h0, line_req[2]}, 32'h1);
        set_line(2, 2'd2, 1'b1);
        chk("R10 code change clears", {31'h0, line_req[2]}, 32'h0);
        tick(3);
        chk("R10 stays clear", {31'h0, line_req[2]}, 32'h0);
    endtask

    initial begin
        for (int n = 0; n < 4; n++) begin
            sh_sense[n] = 2'd0;
            sh_en[n]    = 1'b0;
        end
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_readback();
        t_level_high();
        t_level_low();
        t_edges();
        t_same_cycle();
        t_masked();
        t_sense_change();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule